// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block drives the processor side of the conversation with an attached coprocessor for a single coprocessor instruction. It covers internal coprocessor operations, one-word moves between a core register and the coprocessor in either direction, and memory loads and stores whose data passes through the coprocessor. On every step the sequencer shows a phase code, and the coprocessor answers with a response code. A busy answer holds the instruction in a loop of one idle cycle followed by a re-offered busy phase. A pending exception seen in an idle cycle abandons the instruction after the coprocessor is told about it.

Memory transfers use the start address as given (post-indexed). The next word address is four bytes on each time the coprocessor answers increment. Bad start addresses are refused before any handshake. Memory faults seen during the transfer are collected and reported with the completion pulse. The caller gives one `start` pulse while the block is idle. It then waits for `done` and reads the status outputs, which hold their values until the next start.

Top module: `cop_handshake_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd`, `mem_wr` and every status flag are 0, and `cp_phase` is 0 (no phase).
- R2: A start with a legal op (0 internal op, 1 core-to-coprocessor, 2 coprocessor-to-core, 3 load, 4 store) shows phase 1 (first) in the next cycle, with `cp_to_word` equal to `src_word`. For ops 0 and 1, a ready response (code 0) there gives a single-cycle `done` in the next cycle with no trap.
- R3: A busy response (code 1) to phase 1 or 2 gives exactly one cycle with phase 0. Phase 2 (busy) then follows, and this repeats for as long as busy is answered.
- R4: In the idle cycle of a busy wait, a pending exception gives phase 3 (interrupt) in the next cycle. After that comes `done` with `intr_taken`=1 and no memory access.
- R5: Exception priority is as follows. A low `rst_line_n` gives `exc_kind`=1. Otherwise `fiq_n` low while `fiq_mask` is 0 gives 2. Otherwise `irq_n` low while `irq_mask` is 0 gives 3. Masked lines are ignored and the wait goes on.
- R6: A can't response (code 2) to phase 1 or 2 ends the instruction in the next cycle. Ops 0–2 raise `undef_trap`, and ops 3–4 raise `cp_abort`.
- R7: For op 2, `result_word` is the `cp_from_word` value present with the ready response. On can't it is `cc_flags` in the top four bits with zeros below, and on an abandoned instruction it is 0.
- R8: A load shows phase 4 (transfer) together with `mem_rd` at the start address. Phase 5 (data) follows, with the read word on `cp_to_word`. An increment response (code 3) gives a read at the address plus 4 in the next cycle, then phase 5 again.
- R9: A store shows phase 5 and captures `cp_from_word`. The next cycle writes that word with `mem_wr` at the current address. If the data phase was answered with increment, phase 5 comes again at the address plus 4.
- R10: A load or store whose start address has any bit at or above bit 26 set, or a store below byte address 32, gives `done` with `addr_abort` in the next cycle. No phase is shown in that case.
- R11: `mem_fault` sampled in any read or write cycle is latched and shown as `mem_abort` at `done`, and the transfer still runs to its end.
- R12: `base_wb` is 1 in the `done` cycle exactly when `wb_bit` was set and a load or store reached its memory phases.
- R13: Op codes 5 to 7 give `done` with `undef_trap` in the next cycle, with no phase shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (idle only) |
| op_kind | input | 3 | Instruction class |
| wb_bit | input | 1 | Base writeback requested |
| start_addr | input | AW | First memory byte address |
| src_word | input | DW | Core register value for op 1 |
| cc_flags | input | 4 | Current condition-code bits |
| rst_line_n | input | 1 | Reset request, active low |
| fiq_n | input | 1 | Fast interrupt, active low |
| irq_n | input | 1 | Normal interrupt, active low |
| fiq_mask | input | 1 | Fast interrupt disabled |
| irq_mask | input | 1 | Normal interrupt disabled |
| cp_phase | output | 3 | Phase code shown to coprocessor |
| cp_resp | input | 2 | Coprocessor response |
| cp_to_word | output | DW | Word given to the coprocessor |
| cp_from_word | input | DW | Word supplied by the coprocessor |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (same cycle) |
| mem_fault | input | 1 | Memory abort for this access |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| undef_trap | output | 1 | Undefined-instruction trap |
| cp_abort | output | 1 | Coprocessor refused a memory op |
| addr_abort | output | 1 | Start address refused |
| mem_abort | output | 1 | A memory access faulted |
| intr_taken | output | 1 | Instruction abandoned for an exception |
| exc_kind | output | 2 | Exception that was taken |
| base_wb | output | 1 | Write back the base register |
| result_word | output | DW | Value returned for op 2 |

## Verification
The hardest states to reach are those where an exception must be noticed. This can only happen in the idle cycle of a busy wait, so the coprocessor model has to answer busy at least once while the exception lines are already driven. The stimulus sets each combination of lines and masks before the start pulse and lets the scripted coprocessor stall for a chosen count. The same script chains increment answers and places a memory fault on a chosen word, so that long transfers with a late fault are reached on purpose as well as at random.

// File: rtl/cophs_pkg.sv
package cophs_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_BUSY  = 3'd2,
    PH_INTR  = 3'd3,
    PH_XFER  = 3'd4,
    PH_DATA  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    RSP_READY = 2'd0,
    RSP_BUSY  = 2'd1,
    RSP_CANT  = 2'd2,
    RSP_INC   = 2'd3
  } resp_e;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_RESET  = 2'd1,
    EXC_FAST   = 2'd2,
    EXC_NORMAL = 2'd3
  } exc_e;

  localparam logic [2:0] OP_CALC    = 3'd0;
  localparam logic [2:0] OP_TO_CP   = 3'd1;
  localparam logic [2:0] OP_FROM_CP = 3'd2;
  localparam logic [2:0] OP_LOAD    = 3'd3;
  localparam logic [2:0] OP_STORE   = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR,
    S_XFER, S_LDATA, S_LREAD, S_SDATA, S_SWR, S_DONE
  } seq_state_e;

  function automatic logic op_is_mem(input logic [2:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic op_is_legal(input logic [2:0] op);
    return op <= OP_STORE;
  endfunction

endpackage

// File: rtl/cophs_exc_prio.sv
module cophs_exc_prio
  import cophs_pkg::*;
(
  input  logic       rst_line_n,
  input  logic       fiq_n,
  input  logic       irq_n,
  input  logic       fiq_mask,
  input  logic       irq_mask,
  output logic       pending,
  output logic [1:0] kind
);
  exc_e sel;

  always_comb begin
    if (!rst_line_n)              sel = EXC_RESET;
    else if (!fiq_n && !fiq_mask) sel = EXC_FAST;
    else if (!irq_n && !irq_mask) sel = EXC_NORMAL;
    else                          sel = EXC_NONE;
  end

  assign kind    = sel;
  assign pending = (sel != EXC_NONE);
endmodule

// File: rtl/cophs_addr_unit.sv
module cophs_addr_unit #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int OK_BITS    = 26,
  parameter int VEC_TOP    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          is_store,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic          fault
);
  logic high_bad;
  logic vec_bad;

  generate
    if (OK_BITS < AW) begin : g_range
      assign high_bad = |load_addr[AW-1:OK_BITS];
    end else begin : g_norange
      assign high_bad = 1'b0;
    end
  endgenerate

  assign vec_bad = is_store && (load_addr < AW'(VEC_TOP));
  assign fault   = high_bad || vec_bad;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_addr;
    else if (step) addr_q <= addr_q + AW'(WORD_BYTES);
  end
endmodule

// File: rtl/cop_handshake_seq.sv
module cop_handshake_seq
  import cophs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int FLAG_BITS = 4,
  parameter int OK_BITS   = 26,
  parameter int VEC_TOP   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2:0]           op_kind,
  input  logic                 wb_bit,
  input  logic [AW-1:0]        start_addr,
  input  logic [DW-1:0]        src_word,
  input  logic [FLAG_BITS-1:0] cc_flags,
  input  logic                 rst_line_n,
  input  logic                 fiq_n,
  input  logic                 irq_n,
  input  logic                 fiq_mask,
  input  logic                 irq_mask,
  output logic [2:0]           cp_phase,
  input  logic [1:0]           cp_resp,
  output logic [DW-1:0]        cp_to_word,
  input  logic [DW-1:0]        cp_from_word,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  input  logic                 mem_fault,
  output logic                 busy,
  output logic                 done,
  output logic                 undef_trap,
  output logic                 cp_abort,
  output logic                 addr_abort,
  output logic                 mem_abort,
  output logic                 intr_taken,
  output logic [1:0]           exc_kind,
  output logic                 base_wb,
  output logic [DW-1:0]        result_word
);
  localparam int WORD_BYTES = DW / 8;

  seq_state_e    state;
  logic [2:0]    op_q;
  logic          wb_q;
  logic          reached_q;
  logic          st_inc_q;
  logic [DW-1:0] word_q;

  logic          exc_pend;
  logic [1:0]    exc_sel;
  logic          addr_load;
  logic          addr_step;
  logic          addr_fault;
  logic [AW-1:0] addr_q;
  logic          resp_inc;

  cophs_exc_prio u_prio (
    .rst_line_n (rst_line_n),
    .fiq_n      (fiq_n),
    .irq_n      (irq_n),
    .fiq_mask   (fiq_mask),
    .irq_mask   (irq_mask),
    .pending    (exc_pend),
    .kind       (exc_sel)
  );

  assign addr_load = (state == S_IDLE) && start;
  assign resp_inc  = (cp_resp == RSP_INC);
  assign addr_step = ((state == S_LDATA) && resp_inc) ||
                     ((state == S_SWR) && st_inc_q);

  cophs_addr_unit #(
    .AW         (AW),
    .WORD_BYTES (WORD_BYTES),
    .OK_BITS    (OK_BITS),
    .VEC_TOP    (VEC_TOP)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (addr_load),
    .load_addr (start_addr),
    .is_store  (op_kind == OP_STORE),
    .step      (addr_step),
    .addr_q    (addr_q),
    .fault     (addr_fault)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      op_q        <= '0;
      wb_q        <= 1'b0;
      reached_q   <= 1'b0;
      st_inc_q    <= 1'b0;
      word_q      <= '0;
      undef_trap  <= 1'b0;
      cp_abort    <= 1'b0;
      addr_abort  <= 1'b0;
      mem_abort   <= 1'b0;
      intr_taken  <= 1'b0;
      exc_kind    <= '0;
      result_word <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q        <= op_kind;
          wb_q        <= wb_bit;
          word_q      <= src_word;
          reached_q   <= 1'b0;
          st_inc_q    <= 1'b0;
          undef_trap  <= 1'b0;
          cp_abort    <= 1'b0;
          addr_abort  <= 1'b0;
          mem_abort   <= 1'b0;
          intr_taken  <= 1'b0;
          exc_kind    <= '0;
          result_word <= '0;
          if (!op_is_legal(op_kind)) begin
            undef_trap <= 1'b1;
            state      <= S_DONE;
          end else if (op_is_mem(op_kind) && addr_fault) begin
            addr_abort <= 1'b1;
            state      <= S_DONE;
          end else begin
            state <= S_FIRST;
          end
        end
        S_FIRST, S_BUSY: begin
          case (cp_resp)
            RSP_BUSY: state <= S_WAIT;
            RSP_CANT: begin
              if (op_is_mem(op_q)) cp_abort   <= 1'b1;
              else                 undef_trap <= 1'b1;
              if (op_q == OP_FROM_CP)
                result_word <= {cc_flags, {(DW-FLAG_BITS){1'b0}}};
              state <= S_DONE;
            end
            default: begin
              if (op_q == OP_LOAD) begin
                reached_q <= 1'b1;
                state     <= S_XFER;
              end else if (op_q == OP_STORE) begin
                reached_q <= 1'b1;
                state     <= S_SDATA;
              end else begin
                if (op_q == OP_FROM_CP) result_word <= cp_from_word;
                state <= S_DONE;
              end
            end
          endcase
        end
        S_WAIT: begin
          if (exc_pend) begin
            exc_kind <= exc_sel;
            state    <= S_INTR;
          end else begin
            state <= S_BUSY;
          end
        end
        S_INTR: begin
          intr_taken <= 1'b1;
          state      <= S_DONE;
        end
        S_XFER, S_LREAD: begin
          word_q <= mem_rdata;
          if (mem_fault) mem_abort <= 1'b1;
          state <= S_LDATA;
        end
        S_LDATA: state <= resp_inc ? S_LREAD : S_DONE;
        S_SDATA: begin
          word_q   <= cp_from_word;
          st_inc_q <= resp_inc;
          state    <= S_SWR;
        end
        S_SWR: begin
          if (mem_fault) mem_abort <= 1'b1;
          state <= st_inc_q ? S_SDATA : S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Outputs decoded from registered state
  phase_e ph;
  always_comb begin
    case (state)
      S_FIRST:          ph = PH_FIRST;
      S_BUSY:           ph = PH_BUSY;
      S_INTR:           ph = PH_INTR;
      S_XFER:           ph = PH_XFER;
      S_LDATA, S_SDATA: ph = PH_DATA;
      default:          ph = PH_NONE;
    endcase
  end

  assign cp_phase   = ph;
  assign cp_to_word = word_q;
  assign mem_rd     = (state == S_XFER) || (state == S_LREAD);
  assign mem_wr     = (state == S_SWR);
  assign mem_addr   = addr_q;
  assign mem_wdata  = word_q;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign base_wb    = (state == S_DONE) && wb_q && reached_q;
endmodule

// File: rtl/cophs_checker.sv
module cophs_checker #(
  parameter int AW = 32,
  parameter int WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cp_phase,
  input logic [1:0]    cp_resp,
  input logic [2:0]    op_q,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          undef_trap,
  input logic          cp_abort,
  input logic          intr_taken
);
  logic hs_phase;
  assign hs_phase = (cp_phase == 3'd1) || (cp_phase == 3'd2);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_rd && !mem_wr && cp_phase == 3'd0));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  assert_idle_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (hs_phase && cp_resp == 2'd1) |=> (cp_phase == 3'd0 && !done));

  assert_intr_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (cp_phase == 3'd3) |=> (done && intr_taken && !mem_rd && !mem_wr));

  assert_cant_traps_R6: assert property (@(posedge clk) disable iff (rst)
    (hs_phase && cp_resp == 2'd2) |=> (done && (undef_trap != cp_abort)));

  assert_load_step_R8: assert property (@(posedge clk) disable iff (rst)
    (cp_phase == 3'd5 && cp_resp == 2'd3 && op_q == 3'd3)
      |=> (mem_rd && mem_addr == $past(mem_addr) + AW'(WORD_BYTES)));

  assert_store_write_R9: assert property (@(posedge clk) disable iff (rst)
    (cp_phase == 3'd5 && op_q == 3'd4) |=> (mem_wr && $stable(mem_addr)));

  assert_mem_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, cp_phase == 3'd1, cp_phase == 3'd2}));
endmodule

bind cop_handshake_seq cophs_checker #(.AW(AW), .WORD_BYTES(DW/8)) u_cophs_checker (
  .clk        (clk),
  .rst        (rst),
  .cp_phase   (cp_phase),
  .cp_resp    (cp_resp),
  .op_q       (op_q),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .done       (done),
  .undef_trap (undef_trap),
  .cp_abort   (cp_abort),
  .intr_taken (intr_taken)
);

// File: tb/cop_handshake_seq_bench.sv
`timescale 1ns/1ps
module cop_handshake_seq_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    op_kind = '0;
  logic          wb_bit = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] src_word = '0;
  logic [3:0]    cc_flags = 4'hA;
  logic          rst_line_n = 1'b1, fiq_n = 1'b1, irq_n = 1'b1;
  logic          fiq_mask = 1'b0, irq_mask = 1'b0;
  logic [2:0]    cp_phase;
  logic [1:0]    cp_resp = '0;
  logic [DW-1:0] cp_to_word;
  logic [DW-1:0] cp_from_word = '0;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_fault = 1'b0;
  logic          busy, done, undef_trap, cp_abort, addr_abort, mem_abort;
  logic          intr_taken, base_wb;
  logic [1:0]    exc_kind;
  logic [DW-1:0] result_word;

  int total = 0;
  int bad = 0;

  cop_handshake_seq u_cop_handshake_seq (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memval(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] copval(input int j);
    return 32'hCAFE0000 + 32'(j * 17);
  endfunction

  // exc: 0 none,1 reset,2 fast,3 normal,4 both masked,5 all,6 fast+normal
  function automatic int exc_expect(input int exc);
    case (exc)
      1: return 1; 2: return 2; 3: return 3;
      5: return 1; 6: return 2; default: return 0;
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [31:0] addr, input bit wb,
                     input int nbusy, input int exc, input bit cant,
                     input int ninc, input int fault_at);
    bit   addr_bad, undef_op, exc_taken, hs_ok, mem_ph;
    int   kind, naccess, exp_cycles, cycles, nb_left, inc_left;
    int   nrd, nwr, nsd, nintr;
    logic [31:0] exp_res, last_rd;
    addr_bad = (op == 3 || op == 4) &&
               ((addr[31:26] != 0) || (op == 4 && addr < 32));
    undef_op = (op > 4);
    kind     = exc_expect(exc);
    exc_taken = !addr_bad && !undef_op && nbusy > 0 && kind != 0;
    hs_ok    = !addr_bad && !undef_op && !exc_taken;
    mem_ph   = hs_ok && !cant && (op == 3 || op == 4);
    naccess  = mem_ph ? ninc + 1 : 0;
    if (addr_bad || undef_op) exp_cycles = 1;
    else if (exc_taken)       exp_cycles = 4;
    else exp_cycles = 2 + 2 * nbusy + (mem_ph ? 2 + 2 * ninc : 0);
    if (exc_taken) exp_res = 0;
    else if (cant) exp_res = {cc_flags, 28'h0};
    else           exp_res = 32'h5EED0000 ^ 32'(nbusy);

    @(negedge clk);
    op_kind = op; start_addr = addr; wb_bit = wb;
    src_word = 32'h51C0_0000 + 32'(nbusy);
    rst_line_n = !(exc == 1 || exc == 5);
    fiq_n = !(exc == 2 || exc == 4 || exc == 5 || exc == 6);
    irq_n = !(exc == 3 || exc == 4 || exc == 5 || exc == 6);
    fiq_mask = (exc == 4); irq_mask = (exc == 4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0; nb_left = nbusy; inc_left = ninc;
    nrd = 0; nwr = 0; nsd = 0; nintr = 0; last_rd = 0;
    while (cycles < 200) begin
      cycles++;
      cp_resp = 2'd0; mem_fault = 1'b0; mem_rdata = '0;
      if (cycles == 1 && hs_ok)
        chk(cp_phase == 3'd1 && cp_to_word == src_word, "R2", "first phase",
            {29'b0, cp_phase}, 32'd1);
      if (cp_phase == 3'd1 || cp_phase == 3'd2) begin
        cp_from_word = 32'h5EED0000 ^ 32'(nbusy);
        if (nb_left > 0) begin cp_resp = 2'd1; nb_left--; end
        else cp_resp = cant ? 2'd2 : 2'd0;
      end
      if (cp_phase == 3'd3) nintr++;
      if (mem_rd) begin
        chk(mem_addr == addr + 32'(4 * nrd), "R8", "read addr", mem_addr, addr + 32'(4 * nrd));
        mem_rdata = memval(mem_addr); last_rd = mem_rdata;
        mem_fault = (nrd == fault_at);
        nrd++;
      end
      if (mem_wr) begin
        chk(mem_addr == addr + 32'(4 * nwr), "R9", "write addr", mem_addr, addr + 32'(4 * nwr));
        chk(mem_wdata == copval(nwr), "R9", "write data", mem_wdata, copval(nwr));
        mem_fault = (nwr == fault_at);
        nwr++;
      end
      if (cp_phase == 3'd5) begin
        if (op == 3)
          chk(cp_to_word == last_rd, "R8", "load word to cop", cp_to_word, last_rd);
        else begin
          cp_from_word = copval(nsd); nsd++;
        end
        if (inc_left > 0) begin cp_resp = 2'd3; inc_left--; end
      end
      if (done) break;
      @(negedge clk);
    end
    chk(cycles == exp_cycles, "R3", "cycles to done", cycles, exp_cycles);
    chk(undef_trap == (undef_op || (hs_ok && cant && op <= 2)), "R6", "undef_trap (R13)",
        undef_trap, (undef_op || (hs_ok && cant && op <= 2)));
    chk(cp_abort == (hs_ok && cant && (op == 3 || op == 4)), "R6", "cp_abort",
        cp_abort, (hs_ok && cant && (op == 3 || op == 4)));
    chk(addr_abort == addr_bad, "R10", "addr_abort", addr_abort, addr_bad);
    chk(intr_taken == exc_taken && nintr == int'(exc_taken), "R4", "interrupt",
        intr_taken, exc_taken);
    if (exc_taken) chk(exc_kind == 2'(kind), "R5", "exc_kind", exc_kind, kind);
    chk(nrd + nwr == naccess, "R11", "access count", nrd + nwr, naccess);
    chk(mem_abort == (mem_ph && fault_at < naccess), "R11", "mem_abort",
        mem_abort, (mem_ph && fault_at < naccess));
    chk(base_wb == (wb && mem_ph), "R12", "base_wb", base_wb, (wb && mem_ph));
    if (op == 2) chk(result_word == exp_res, "R7", "result_word", result_word, exp_res);
    rst_line_n = 1'b1; fiq_n = 1'b1; irq_n = 1'b1; fiq_mask = 1'b0; irq_mask = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R2", "back to idle", busy, 0);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && cp_phase == 0 && !undef_trap &&
        !cp_abort && !addr_abort && !mem_abort && !intr_taken && !base_wb,
        "R1", "reset state", {busy, done, mem_rd, mem_wr}, 0);
    // directed corner cases
    run(3'd0, 32'h100, 0, 0, 0, 0, 0, 99);        // R2 plain op
    run(3'd1, 32'h100, 0, 3, 0, 0, 0, 99);        // R3 long busy wait
    run(3'd2, 32'h100, 0, 1, 0, 0, 0, 99);        // R7 ready
    run(3'd2, 32'h100, 0, 2, 0, 1, 0, 99);        // R7 can't -> flags
    run(3'd3, 32'h2000, 1, 0, 0, 0, 3, 99);       // R8 R12 load burst
    run(3'd4, 32'h2000, 1, 1, 0, 0, 2, 99);       // R9 store burst
    run(3'd3, 32'h3000, 0, 0, 0, 0, 3, 2);        // R11 late fault
    run(3'd4, 32'h3000, 0, 0, 0, 0, 1, 0);        // R11 store fault
    run(3'd0, 32'h0, 0, 2, 3, 0, 0, 99);          // R4 normal interrupt
    run(3'd3, 32'h40, 1, 1, 5, 0, 0, 99);         // R5 reset wins
    run(3'd1, 32'h0, 0, 1, 6, 0, 0, 99);          // R5 fast beats normal
    run(3'd2, 32'h0, 0, 2, 4, 0, 0, 99);          // R5 masked ignored
    run(3'd1, 32'h0, 0, 0, 3, 0, 0, 99);          // R4 no wait, not taken
    run(3'd4, 32'h10, 1, 0, 0, 0, 0, 99);         // R10 vector store
    run(3'd3, 32'h10, 0, 0, 0, 0, 0, 99);         // R10 low load allowed
    run(3'd3, 32'h0400_0000, 1, 0, 0, 0, 0, 99);  // R10 high load
    run(3'd4, 32'h1000, 0, 1, 0, 1, 0, 99);       // R6 store refused
    run(3'd0, 32'h1000, 0, 0, 0, 1, 0, 99);       // R6 op refused
    run(3'd6, 32'h1000, 0, 0, 0, 0, 0, 99);       // R13 bad op
    // constrained random
    for (int i = 0; i < 120; i++) begin
      logic [31:0] a;
      a = {($urandom % 8 == 0) ? 6'($urandom) : 6'd0, 24'($urandom), 2'b00};
      run(3'($urandom % 8), a, 1'($urandom), int'($urandom % 4),
          int'($urandom % 7), ($urandom % 5 == 0), int'($urandom % 5),
          int'($urandom % 8));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule